// File: doc/BRIEF.md
# Two-Direction Crossing Light Sequencer

This block drives the lamps at a crossing of an avenue (direction A) and a road (direction B). A control state machine decides the phase, and a datapath holds a down-counting seconds timer together with two clock dividers. The dividers turn the 200 Hz system clock into a one-second tick and a 2 Hz flash. Each green time is set in whole seconds by an 8-bit switch value. Yellow always lasts five seconds. The remaining seconds of the current phase are shown on an output for a display.

The block also reacts to its surroundings. A night flag from an external time-of-day source blanks all red and green lamps and flashes both yellow lamps together. Car-presence sensors let the busy direction keep green while the empty direction stays red. A pedestrian button on the held-red direction releases that hold. Any pedestrian call is stored until the next green of its own direction. That green then lasts five seconds longer and lights a walk lamp. A tone-enable output is active during each daytime yellow phase.

Top module: `trafficCtrl`

## Requirements
- R1: Outside night mode, direction A runs green, yellow, red and then again green; B does the same. At every cycle, at least one of the two directions shows red. Each direction shows exactly one lamp at a time.
- R2: A green lasts max(1, greenTimeA) seconds, and this is also the red time of B. B green lasts max(1, greenTimeB) seconds, and this is also the red time of A. Each value is read when its green phase is loaded.
- R3: Each yellow phase lasts 5 seconds. toneOn is 1 during a daytime yellow phase and 0 at all other times.
- R4: secsLeft is loaded with the duration of the new phase on the same clock edge that starts the phase. It then falls by 1 every 200 clocks (one second), and the phase ends on the tick at which secsLeft is 1. A switch value of 0 counts as 1 second.
- R5: While nightMode is 1, from the next clock on, both red and both green lamps are off, secsLeft is 0, and both yellow lamps show the same flash bit. That bit changes every 50 clocks after reset (2 Hz). When nightMode falls, the next clock starts A green.
- R6: If A green ends while carA=1, carB=0 and no B pedestrian call is stored, A stays green, B stays red and secsLeft stays at 1. The mirror rule holds for B green.
- R7: A B pedestrian call stored during such a hold ends the A green at the next one-second tick. The mirror rule holds for an A call.
- R8: A press of walkReqA or walkReqB is stored until the next green of that direction starts. That green is then 5 seconds longer, and its walk lamp (walkA or walkB) is lit for the whole green. The stored call is then cleared, so the following green of that direction is normal again.
- R9: After reset, A is green, B is red, the walk lamps and the tone are off, and secsLeft equals max(1, greenTimeA).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 Hz system clock |
| rstN | input | 1 | Synchronous active-low reset |
| nightMode | input | 1 | Night flag from time-of-day source |
| carA | input | 1 | Car present on avenue A |
| carB | input | 1 | Car present on road B |
| walkReqA | input | 1 | Pedestrian button, direction A |
| walkReqB | input | 1 | Pedestrian button, direction B |
| greenTimeA | input | 8 | A green seconds (B red time) |
| greenTimeB | input | 8 | B green seconds (A red time) |
| aGreen | output | 1 | A green lamp |
| aYellow | output | 1 | A yellow lamp |
| aRed | output | 1 | A red lamp |
| bGreen | output | 1 | B green lamp |
| bYellow | output | 1 | B yellow lamp |
| bRed | output | 1 | B red lamp |
| walkA | output | 1 | Walk lamp for direction A |
| walkB | output | 1 | Walk lamp for direction B |
| toneOn | output | 1 | Enable for the audible yellow signal |
| secsLeft | output | 9 | Seconds left in the current phase |

## Verification
A wrong phase register shows up at the lamp pins on the very next clock. A corrupted seconds counter shows up on secsLeft within one tick, that is within 200 clocks, and it moves every later phase boundary by whole seconds. The bench therefore checks lamps and counter at the exact cycles where a phase must start. A stuck or lost pedestrian latch only shows at the next green of that direction: as a missing or extra five seconds and a wrong walk lamp. The bench therefore follows each call through to its served green and one green beyond. The flash phase is fixed from reset, so a divider fault shows as the wrong yellow level at a known cycle.

// File: rtl/tlcPkg.sv
package tlcPkg;
  typedef enum logic [2:0] {
    PH_A_GO, PH_A_WARN, PH_B_GO, PH_B_WARN, PH_DARK
  } phaseT;

  typedef enum logic [2:0] {
    LD_NONE, LD_GO_A, LD_GO_B, LD_WARN, LD_ZERO
  } loadSelT;

  typedef struct packed {
    loadSelT sel;
    logic    extend;
  } tmrCmdT;
endpackage

// File: rtl/tlcDivider.sv
module tlcDivider #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rstN,
  output logic pulse
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign pulse = (cnt == LAST);
endmodule

// File: rtl/tlcTimer.sv
module tlcTimer
  import tlcPkg::*;
#(
  parameter int CLK_HZ   = 200,
  parameter int FLASH_HZ = 2,
  parameter int DUR_W    = 8,
  parameter int WARN_S   = 5,
  parameter int EXTRA_S  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmdT           cmd,
  input  logic [DUR_W-1:0] greenTimeA,
  input  logic [DUR_W-1:0] greenTimeB,
  output logic             expire,
  output logic             flashOn,
  output logic [DUR_W:0]   secsLeft
);
  localparam int CNT_W      = DUR_W + 1;
  localparam int FLASH_HALF = CLK_HZ / (2 * FLASH_HZ);

  logic tick, flashPulse;
  logic [CNT_W-1:0] cnt, loadVal, goA, goB, extra;

  generate
    for (genvar g = 0; g < 2; g++) begin : gDiv
      if (g == 0) begin : gSec
        tlcDivider #(.DIV(CLK_HZ)) uDiv (.clk(clk), .rstN(rstN), .pulse(tick));
      end else begin : gFlash
        tlcDivider #(.DIV(FLASH_HALF)) uDiv (.clk(clk), .rstN(rstN), .pulse(flashPulse));
      end
    end
  endgenerate

  always_comb begin
    goA   = (greenTimeA == '0) ? CNT_W'(1) : CNT_W'(greenTimeA);
    goB   = (greenTimeB == '0) ? CNT_W'(1) : CNT_W'(greenTimeB);
    extra = cmd.extend ? CNT_W'(EXTRA_S) : '0;
    unique case (cmd.sel)
      LD_GO_A: loadVal = goA + extra;
      LD_GO_B: loadVal = goB + extra;
      LD_WARN: loadVal = CNT_W'(WARN_S);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         cnt <= goA;
    else if (cmd.sel != LD_NONE)       cnt <= loadVal;
    else if (tick && cnt > CNT_W'(1))  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           flashOn <= 1'b0;
    else if (flashPulse) flashOn <= ~flashOn;
  end

  assign expire   = tick && (cnt == CNT_W'(1));
  assign secsLeft = cnt;

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cnt > CNT_W'(1) && cmd.sel == LD_NONE) |=> (cnt == $past(cnt) - 1'b1));

  p_green_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.sel == LD_GO_A || cmd.sel == LD_GO_B) |=> (cnt >= CNT_W'(1)));

  p_warn_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.sel == LD_WARN) |=> (cnt == CNT_W'(WARN_S)));
endmodule

// File: rtl/tlcControl.sv
module tlcControl
  import tlcPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   nightMode,
  input  logic   carA,
  input  logic   carB,
  input  logic   walkReqA,
  input  logic   walkReqB,
  input  logic   expire,
  input  logic   flashOn,
  output tmrCmdT cmd,
  output logic   aGreen,
  output logic   aYellow,
  output logic   aRed,
  output logic   bGreen,
  output logic   bYellow,
  output logic   bRed,
  output logic   walkA,
  output logic   walkB,
  output logic   toneOn
);
  phaseT phase, nxt;
  logic  pendA, pendB, servingA, servingB;
  logic  holdA, holdB;

  assign holdA = carA && !carB && !pendB;
  assign holdB = carB && !carA && !pendA;

  always_comb begin
    nxt        = phase;
    cmd.sel    = LD_NONE;
    cmd.extend = 1'b0;
    if (nightMode) begin
      if (phase != PH_DARK) begin
        nxt     = PH_DARK;
        cmd.sel = LD_ZERO;
      end
    end else begin
      unique case (phase)
        PH_DARK: begin
          nxt = PH_A_GO; cmd.sel = LD_GO_A; cmd.extend = pendA;
        end
        PH_A_GO: if (expire && !holdA) begin
          nxt = PH_A_WARN; cmd.sel = LD_WARN;
        end
        PH_A_WARN: if (expire) begin
          nxt = PH_B_GO; cmd.sel = LD_GO_B; cmd.extend = pendB;
        end
        PH_B_GO: if (expire && !holdB) begin
          nxt = PH_B_WARN; cmd.sel = LD_WARN;
        end
        PH_B_WARN: if (expire) begin
          nxt = PH_A_GO; cmd.sel = LD_GO_A; cmd.extend = pendA;
        end
        default: begin
          nxt = PH_A_GO; cmd.sel = LD_GO_A;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_A_GO;
      pendA    <= 1'b0;
      pendB    <= 1'b0;
      servingA <= 1'b0;
      servingB <= 1'b0;
    end else begin
      phase <= nxt;
      if (cmd.sel == LD_GO_A) begin
        pendA    <= 1'b0;
        servingA <= pendA;
      end else if (walkReqA) begin
        pendA <= 1'b1;
      end
      if (cmd.sel == LD_GO_B) begin
        pendB    <= 1'b0;
        servingB <= pendB;
      end else if (walkReqB) begin
        pendB <= 1'b1;
      end
    end
  end

  always_comb begin
    aGreen  = (phase == PH_A_GO);
    aYellow = (phase == PH_A_WARN) || (phase == PH_DARK && flashOn);
    aRed    = (phase == PH_B_GO) || (phase == PH_B_WARN);
    bGreen  = (phase == PH_B_GO);
    bYellow = (phase == PH_B_WARN) || (phase == PH_DARK && flashOn);
    bRed    = (phase == PH_A_GO) || (phase == PH_A_WARN);
    walkA   = (phase == PH_A_GO) && servingA;
    walkB   = (phase == PH_B_GO) && servingB;
    toneOn  = (phase == PH_A_WARN) || (phase == PH_B_WARN);
  end

  p_interlock_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DARK) |-> (aRed || bRed));

  p_warn_after_go_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_A_WARN && $past(phase) != PH_A_WARN) |-> ($past(phase) == PH_A_GO));

  p_one_lamp_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DARK) |-> ($countones({aGreen, aYellow, aRed}) == 1
                            && $countones({bGreen, bYellow, bRed}) == 1));

  p_tone_day_r3: assert property (@(posedge clk) disable iff (!rstN)
    toneOn |-> ($onehot({aYellow, bYellow}) && !nightMode));

  p_dark_lamps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DARK) |-> (!(aGreen || aRed || bGreen || bRed) && aYellow == bYellow));

  p_hold_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_A_GO && expire && carA && !carB && !pendB && !nightMode) |=> (phase == PH_A_GO));

  p_release_a_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_A_GO && expire && pendB && !nightMode) |=> (phase == PH_A_WARN));

  p_walk_green_r8: assert property (@(posedge clk) disable iff (!rstN)
    (walkA || walkB) |-> (aGreen || bGreen));
endmodule

// File: rtl/trafficCtrl.sv
module trafficCtrl
  import tlcPkg::*;
#(
  parameter int CLK_HZ   = 200,
  parameter int FLASH_HZ = 2,
  parameter int DUR_W    = 8,
  parameter int WARN_S   = 5,
  parameter int EXTRA_S  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nightMode,
  input  logic             carA,
  input  logic             carB,
  input  logic             walkReqA,
  input  logic             walkReqB,
  input  logic [DUR_W-1:0] greenTimeA,
  input  logic [DUR_W-1:0] greenTimeB,
  output logic             aGreen,
  output logic             aYellow,
  output logic             aRed,
  output logic             bGreen,
  output logic             bYellow,
  output logic             bRed,
  output logic             walkA,
  output logic             walkB,
  output logic             toneOn,
  output logic [DUR_W:0]   secsLeft
);
  tmrCmdT cmd;
  logic   expire, flashOn;

  tlcTimer #(
    .CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ), .DUR_W(DUR_W),
    .WARN_S(WARN_S), .EXTRA_S(EXTRA_S)
  ) uTimer (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .greenTimeA(greenTimeA), .greenTimeB(greenTimeB),
    .expire(expire), .flashOn(flashOn), .secsLeft(secsLeft)
  );

  tlcControl uControl (
    .clk(clk), .rstN(rstN), .nightMode(nightMode),
    .carA(carA), .carB(carB), .walkReqA(walkReqA), .walkReqB(walkReqB),
    .expire(expire), .flashOn(flashOn), .cmd(cmd),
    .aGreen(aGreen), .aYellow(aYellow), .aRed(aRed),
    .bGreen(bGreen), .bYellow(bYellow), .bRed(bRed),
    .walkA(walkA), .walkB(walkB), .toneOn(toneOn)
  );
endmodule

// File: tb/test_trafficCtrl.sv
`timescale 1ns/1ps
module test_trafficCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nightMode = 1'b0, carA = 1'b0, carB = 1'b0;
  logic walkReqA = 1'b0, walkReqB = 1'b0;
  logic [7:0] greenTimeA = 8'd3, greenTimeB = 8'd2;
  logic aGreen, aYellow, aRed, bGreen, bYellow, bRed, walkA, walkB, toneOn;
  logic [8:0] secsLeft;

  int unsigned cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned due;
    string       req;
    logic [5:0]  lamps;
    logic [1:0]  walk;
    logic        tone;
    int          secs;
  } expT;
  expT q[$];

  always #10 clk = ~clk;

  trafficCtrl i_trafficCtrl (
    .clk(clk), .rstN(rstN), .nightMode(nightMode), .carA(carA), .carB(carB),
    .walkReqA(walkReqA), .walkReqB(walkReqB),
    .greenTimeA(greenTimeA), .greenTimeB(greenTimeB),
    .aGreen(aGreen), .aYellow(aYellow), .aRed(aRed),
    .bGreen(bGreen), .bYellow(bYellow), .bRed(bRed),
    .walkA(walkA), .walkB(walkB), .toneOn(toneOn), .secsLeft(secsLeft)
  );

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // lamps = {aGreen,aYellow,aRed,bGreen,bYellow,bRed}; walk = {walkA,walkB}
  task automatic expectAt(input int unsigned due, input string req, input logic [5:0] lamps,
                          input logic [1:0] walk, input logic tone, input int secs);
    expT e;
    e.due = due; e.req = req; e.lamps = lamps; e.walk = walk; e.tone = tone; e.secs = secs;
    q.push_back(e);
  endtask

  task automatic waitCyc(input int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: compares the queued expectation when its cycle arrives
  always @(negedge clk) begin
    while (rstN && q.size() > 0 && q[0].due == cyc) begin
      expT e;
      logic [5:0] lampsNow;
      e = q.pop_front();
      lampsNow = {aGreen, aYellow, aRed, bGreen, bYellow, bRed};
      checks++;
      if (lampsNow !== e.lamps || {walkA, walkB} !== e.walk || toneOn !== e.tone
          || int'(secsLeft) != e.secs) begin
        fails++;
        $display("FAIL %s cyc=%0d actual lamps=%b walk=%b tone=%b secs=%0d expected lamps=%b walk=%b tone=%b secs=%0d",
                 e.req, cyc, lampsNow, {walkA, walkB}, toneOn, secsLeft,
                 e.lamps, e.walk, e.tone, e.secs);
      end
    end
  end

  initial begin
    // driver: pushes expectations, then applies stimulus at the planned cycles
    expectAt(0,     "R9", 6'b100001, 2'b00, 1'b0, 3); // reset state
    expectAt(200,   "R4", 6'b100001, 2'b00, 1'b0, 2); // one-second step
    expectAt(600,   "R3", 6'b010001, 2'b00, 1'b1, 5); // A yellow, tone
    expectAt(1600,  "R2", 6'b001100, 2'b00, 1'b0, 2); // B green from switch
    expectAt(2000,  "R1", 6'b001010, 2'b00, 1'b1, 5); // B yellow
    expectAt(3000,  "R8", 6'b100001, 2'b10, 1'b0, 8); // A green extended, walk A
    expectAt(4600,  "R1", 6'b010001, 2'b00, 1'b1, 5); // A yellow after 8 s
    expectAt(5600,  "R4", 6'b001100, 2'b00, 1'b0, 1); // zero switch -> 1 s
    expectAt(5800,  "R1", 6'b001010, 2'b00, 1'b1, 5);
    expectAt(6800,  "R8", 6'b100001, 2'b00, 1'b0, 3); // call cleared
    expectAt(7400,  "R6", 6'b100001, 2'b00, 1'b0, 1); // hold, B stays red
    expectAt(9000,  "R6", 6'b100001, 2'b00, 1'b0, 1); // still held
    expectAt(9200,  "R7", 6'b010001, 2'b00, 1'b1, 5); // released by B call
    expectAt(10200, "R8", 6'b001100, 2'b01, 1'b0, 6); // B green 1+5, walk B
    expectAt(10301, "R5", 6'b000000, 2'b00, 1'b0, 0); // night, flash low
    expectAt(10351, "R5", 6'b010010, 2'b00, 1'b0, 0); // flash high
    expectAt(10401, "R5", 6'b000000, 2'b00, 1'b0, 0); // flash low
    expectAt(10411, "R5", 6'b100001, 2'b00, 1'b0, 3); // back to A green

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    waitCyc(2000);  greenTimeB = 8'd0;
    waitCyc(2200);  walkReqA = 1'b1;
    @(negedge clk); walkReqA = 1'b0;
    waitCyc(6800);  carA = 1'b1;
    waitCyc(9100);  walkReqB = 1'b1;
    @(negedge clk); walkReqB = 1'b0;
    waitCyc(9200);  carA = 1'b0;
    waitCyc(10300); nightMode = 1'b1;
    waitCyc(10410); nightMode = 1'b0;
    waitCyc(10420);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 10420);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule